// File: doc/BRIEF.md
# Four-Tag Ascending Identifier Sorter with Kill Serializer

This block takes the four tag identifiers gathered in one read cycle, each with a flag telling whether its frame passed the error check. It puts them in ascending order and hands them out one at a time as confirmed identities. A read cycle is one period of the tag clock. The tag clock is a divided copy of the system clock and is sampled as an ordinary input. The block captures the four identifiers when it first sees the tag clock high. A five-comparator tree with four leaves orders the captured set within that tag period. When the block first sees the tag clock low, the ordered set moves into a hold stage.

A serializer takes the held set and presents one identifier per system-clock cycle, smallest first. In each of those cycles it raises a kill strobe and puts the same identifier on the kill output, so the reader can silence the tag. Slots whose frame failed the check never appear. Equal identifiers come out in the order of their input slots, and each emitted identifier reports the slot it came from.

Top module: `tagsort_top`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, id_vld, kill_stb and busy are 0.
- R2: The four identifiers (slot s on id_in[16*s+15:16*s]) and id_ok are captured on the first system edge where tag_clk is sampled 1 after being sampled 0. Changes to id_in later in that tag period have no effect on the emitted values.
- R3: Emitted identifiers of one set appear in ascending unsigned order.
- R4: A slot with id_ok[s]=0 is never emitted or killed, whatever its identifier value (including 0000). A set with no valid slot emits nothing.
- R5: Equal identifiers are emitted in increasing slot order, and slot_out gives the input slot number (0 to 3) of the emitted identifier.
- R6: Let F be the first system edge where tag_clk is sampled 0 after being sampled 1. The k-th emitted identifier (k from 0) is presented after edge F+1+k, one per cycle with no gaps.
- R7: kill_stb is high in exactly the cycles where id_vld is high, and kill_id equals id_out in those cycles.
- R8: busy is 1 from edge F until the cycle carrying the last identifier of the set, and returns to 0 when nothing is pending.
- R9: A set that arrives while the previous one is still draining is held and then emitted directly after it. At a tag period of 4 system cycles, consecutive sets drain back to back with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tag_clk | input | 1 | Tag clock, derived from clk, period at least 4 cycles |
| id_in | input | 64 | Four 16-bit identifiers, slot s at bits 16*s+15:16*s |
| id_ok | input | 4 | Per-slot frame-check pass flag |
| id_out | output | 16 | Emitted identifier |
| slot_out | output | 2 | Input slot of the emitted identifier |
| id_vld | output | 1 | id_out and slot_out carry an identifier |
| kill_stb | output | 1 | Kill command for the emitted tag |
| kill_id | output | 16 | Identifier of the tag being killed |
| busy | output | 1 | A set is held or draining |

## Verification
The timing reference is the edge at which the falling tag clock is first sampled. The k-th item of a set is due in the cycle after edge F+1+k, and busy is due right after edge F. For each set, the driver records F from its own cycle counter and queues every expected identifier with its slot and due cycle. The monitor compares at the falling clock edge in the due cycle. An item that arrives late, early or without a matching entry counts as a failure, and so does an item that has not appeared by its due cycle. Back-to-back sets at the minimum tag period exercise the zero-gap reload.

// File: rtl/tagsort_pkg.sv
// Shared constants for the four-slot identifier sorter.
// A sort key is {invalid flag, identifier, slot number}, so that invalid
// slots order last and equal identifiers order by slot.
package tagsort_pkg;
    localparam int SLOTS = 4;
    localparam int IDX_W = 2;
endpackage

// File: rtl/tagsort_cmpx.sv
// Compare-exchange cell: routes the smaller of two keys to lo and the larger to hi.
// Assumes the keys are unsigned and distinct, which the slot field guarantees.
module tagsort_cmpx #(
    parameter int KW = 19
) (
    input  logic [KW-1:0] a,
    input  logic [KW-1:0] b,
    output logic [KW-1:0] lo,
    output logic [KW-1:0] hi
);
    // Order the pair
    always_comb begin
        if (a > b) begin
            lo = b;
            hi = a;
        end else begin
            lo = a;
            hi = b;
        end
    end
endmodule

// File: rtl/tagsort_net.sv
// Four-leaf sort tree. Two pairs are sorted, then their minimum and maximum
// are merged, and the two middle keys are compared last. Purely combinational.
// Assumes four keys packed with slot 0 at the LSB. The output keeps the same
// packing, with rank 0 (smallest) at the LSB.
module tagsort_net #(
    parameter int KW = 19
) (
    input  logic [4*KW-1:0] k_in,
    output logic [4*KW-1:0] k_out
);
    logic [KW-1:0] s1 [4];
    logic [KW-1:0] s2 [4];
    logic [KW-1:0] mid_lo;
    logic [KW-1:0] mid_hi;

    // Leaf layer: sort the pairs (0,1) and (2,3)
    for (genvar g = 0; g < 2; g++) begin : g_leaf
        tagsort_cmpx #(.KW(KW)) u_pair (
            .a (k_in[(2*g)*KW +: KW]),
            .b (k_in[(2*g+1)*KW +: KW]),
            .lo(s1[2*g]),
            .hi(s1[2*g+1])
        );
    end

    // Merge layer: global minimum and maximum
    for (genvar g = 0; g < 2; g++) begin : g_merge
        tagsort_cmpx #(.KW(KW)) u_merge (
            .a (s1[g]),
            .b (s1[g+2]),
            .lo(s2[g]),
            .hi(s2[g+2])
        );
    end

    // Root: settle the two middle ranks
    tagsort_cmpx #(.KW(KW)) u_root (
        .a (s2[1]),
        .b (s2[2]),
        .lo(mid_lo),
        .hi(mid_hi)
    );

    assign k_out = {s2[3], mid_hi, mid_lo, s2[0]};
endmodule

// File: rtl/tagsort_drain.sv
// Hold stage plus read-kill serializer. The hold register takes the sorted
// set on the handoff pulse. The serializer takes it when idle or on its last
// item, then shifts out one valid key per cycle.
// Assumes handoff pulses are at least 4 cycles apart, so the hold stage
// never overflows.
module tagsort_drain
    import tagsort_pkg::*;
#(
    parameter int ID_W = 16,
    localparam int KW  = 1 + ID_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [4*KW-1:0]   keys,
    output logic [ID_W-1:0]   id_out,
    output logic [IDX_W-1:0]  slot_out,
    output logic              id_vld,
    output logic              busy
);
    logic [4*KW-1:0] hold_key;
    logic            hold_full;
    logic [KW-1:0]   sq [4];
    logic [2:0]      cnt;
    logic [2:0]      nv;
    logic            take;

    // Count valid keys in the held set
    always_comb begin
        nv = 3'd0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!hold_key[i*KW + KW - 1]) nv = nv + 3'd1;
        end
    end

    assign take = hold_full && (cnt <= 3'd1);

    // Hold stage: capture on handoff, release to the serializer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_key  <= '1;
        end else if (load) begin
            hold_full <= 1'b1;
            hold_key  <= keys;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    // Serializer: reload or shift one key per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 3'd0;
            for (int i = 0; i < SLOTS; i++) sq[i] <= '1;
        end else if (take) begin
            cnt <= nv;
            for (int i = 0; i < SLOTS; i++) sq[i] <= hold_key[i*KW +: KW];
        end else if (cnt != 3'd0) begin
            cnt <= cnt - 3'd1;
            for (int i = 0; i < SLOTS - 1; i++) sq[i] <= sq[i+1];
            sq[SLOTS-1] <= '1;
        end
    end

    assign id_vld   = (cnt != 3'd0);
    assign id_out   = sq[0][IDX_W +: ID_W];
    assign slot_out = sq[0][IDX_W-1:0];
    assign busy     = id_vld || hold_full;

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !hold_full); // R9
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !take && !load) |=> (hold_full && $stable(hold_key))); // R9
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= 3'd2) |-> (sq[0] < sq[1])); // R3
    AST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != 3'd0) |-> !sq[0][KW-1]); // R4
    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt > 3'd1) && !take) |=> (cnt == $past(cnt) - 3'd1)); // R6
endmodule

// File: rtl/tagsort_top.sv
// Four-tag ascending sorter with read-kill serializer.
// tag_clk is a divided copy of clk, sampled as data. Its sampled rise
// captures the slot set, and its sampled fall hands the sorted set on.
// Assumes a tag period of at least 4 clk cycles.
module tagsort_top
    import tagsort_pkg::*;
#(
    parameter int ID_W = 16,
    localparam int KW  = 1 + ID_W + IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tag_clk,
    input  logic [SLOTS*ID_W-1:0] id_in,
    input  logic [SLOTS-1:0]      id_ok,
    output logic [ID_W-1:0]       id_out,
    output logic [IDX_W-1:0]      slot_out,
    output logic                  id_vld,
    output logic                  kill_stb,
    output logic [ID_W-1:0]       kill_id,
    output logic                  busy
);
    logic              tag_q;
    logic              tag_rise;
    logic              tag_fall;
    logic [4*KW-1:0]   leaf;
    logic [4*KW-1:0]   ranked;

    // Remember last sampled tag clock level
    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= 1'b0;
        else        tag_q <= tag_clk;
    end

    assign tag_rise = tag_clk && !tag_q;
    assign tag_fall = !tag_clk && tag_q;

    // Capture the slot set as sort keys on the tag clock rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leaf <= '1;
        end else if (tag_rise) begin
            for (int s = 0; s < SLOTS; s++) begin
                leaf[s*KW +: KW] <= {~id_ok[s], id_in[s*ID_W +: ID_W], IDX_W'(s)};
            end
        end
    end

    tagsort_net #(.KW(KW)) u_net (
        .k_in (leaf),
        .k_out(ranked)
    );

    tagsort_drain #(.ID_W(ID_W)) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tag_fall),
        .keys    (ranked),
        .id_out  (id_out),
        .slot_out(slot_out),
        .id_vld  (id_vld),
        .busy    (busy)
    );

    assign kill_stb = id_vld;
    assign kill_id  = id_out;

    AST_LEAF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_rise |=> $stable(leaf)); // R2
    AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        id_vld |-> busy); // R8
endmodule

// File: tb/sim_tagsort_top.sv
module sim_tagsort_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tag_clk = 1'b0;
    logic [63:0] id_in = '0;
    logic [3:0]  id_ok = '0;
    logic [15:0] id_out;
    logic [1:0]  slot_out;
    logic        id_vld;
    logic        kill_stb;
    logic [15:0] kill_id;
    logic        busy;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] cyc = 0;
    bit          done = 0;

    typedef struct packed {
        logic [15:0] id;
        logic [1:0]  slot;
        logic [31:0] due;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    tagsort_top u0 (
        .clk(clk), .rst_n(rst_n), .tag_clk(tag_clk), .id_in(id_in), .id_ok(id_ok),
        .id_out(id_out), .slot_out(slot_out), .id_vld(id_vld), .kill_stb(kill_stb),
        .kill_id(kill_id), .busy(busy)
    );

    // Monitor: compare emitted items against the scoreboard at the due cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (id_vld) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R4 spurious id=%h slot=%0d, expected nothing", id_out, slot_out);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (id_out !== e.id || slot_out !== e.slot || cyc !== e.due) begin
                        errors++;
                        $display("FAIL R3/R5/R6 id=%h slot=%0d cyc=%0d, expected id=%h slot=%0d cyc=%0d",
                                 id_out, slot_out, cyc, e.id, e.slot, e.due);
                    end
                    checks++;
                    if (!kill_stb || kill_id !== id_out) begin
                        errors++;
                        $display("FAIL R7 kill_stb=%b kill_id=%h, expected 1 %h", kill_stb, kill_id, id_out);
                    end
                    checks++;
                    if (!busy) begin
                        errors++;
                        $display("FAIL R8 busy=%b during emission, expected 1", busy);
                    end
                end
            end else begin
                if (kill_stb) begin
                    checks++;
                    errors++;
                    $display("FAIL R7 kill_stb=1 without id_vld, expected 0");
                end
                if (sb.size() != 0 && sb[0].due <= cyc) begin
                    checks++;
                    errors++;
                    $display("FAIL R6 missing id=%h at cyc=%0d, expected due %0d", sb[0].id, cyc, sb[0].due);
                    void'(sb.pop_front());
                end
            end
        end
    end

    // Driver: present one slot set over one tag period and queue expected items
    task automatic run_set(input logic [63:0] ids, input logic [3:0] ok,
                           input int hi, input int lo, input bit alter);
        logic [31:0] f_edge;
        bit          used [4];
        int          k;
        @(negedge clk);
        id_in   = ids;
        id_ok   = ok;
        tag_clk = 1'b1;
        for (int i = 0; i < hi; i++) begin
            @(negedge clk);
            if (alter && i == 0) begin
                id_in = 64'h0000_0000_0000_0000;  // R2: must be ignored
                id_ok = 4'b1111;
            end
        end
        tag_clk = 1'b0;
        f_edge  = cyc + 1;
        k = 0;
        for (int s = 0; s < 4; s++) used[s] = 0;
        for (int n = 0; n < 4; n++) begin
            int best;
            best = -1;
            for (int s = 0; s < 4; s++) begin
                if (ok[s] && !used[s] && (best < 0 || ids[16*s +: 16] < ids[16*best +: 16])) best = s;
            end
            if (best >= 0) begin
                exp_t e;
                used[best] = 1;
                e.id   = ids[16*best +: 16];
                e.slot = best[1:0];
                e.due  = f_edge + 1 + k;
                sb.push_back(e);
                k++;
            end
        end
        for (int i = 0; i < lo; i++) begin
            @(negedge clk);
            if (i == 0) begin
                checks++;
                if (busy !== 1'b1) begin
                    errors++;
                    $display("FAIL R8 busy=%b after handoff edge, expected 1", busy);
                end
            end
        end
    endtask

    // Wait for the drain to finish, then confirm idle outputs
    task automatic settle(input string tag);
        repeat (8) @(negedge clk);
        checks++;
        if (busy !== 1'b0 || id_vld !== 1'b0 || sb.size() != 0) begin
            errors++;
            $display("FAIL %s busy=%b id_vld=%b pending=%0d, expected 0 0 0", tag, busy, id_vld, sb.size());
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (id_vld !== 1'b0 || kill_stb !== 1'b0 || busy !== 1'b0) begin
            errors++;
            $display("FAIL R1 id_vld=%b kill_stb=%b busy=%b, expected 0 0 0", id_vld, kill_stb, busy);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R6: worked example, all slots valid
        run_set({16'hEA60, 16'h0010, 16'h0005, 16'h00C8}, 4'b1111, 4, 4, 0);
        settle("R8 example");
        // R4: slots 1 and 3 invalid
        run_set({16'h0050, 16'h0200, 16'h0100, 16'h0300}, 4'b0101, 4, 4, 0);
        settle("R4 partial");
        // R5: duplicate identifiers keep slot order
        run_set({16'h0777, 16'h0001, 16'h0777, 16'h0777}, 4'b1111, 4, 4, 0);
        settle("R5 duplicates");
        // R4: nothing valid, nothing emitted
        run_set({16'h0001, 16'h0002, 16'h0003, 16'h0004}, 4'b0000, 4, 4, 0);
        settle("R4 empty");
        // R3: extreme values
        run_set({16'h7FFF, 16'h8000, 16'h0000, 16'hFFFF}, 4'b1111, 4, 4, 0);
        settle("R3 extremes");
        // R2: inputs change after capture
        run_set({16'h0001, 16'h0042, 16'h0042, 16'h1234}, 4'b1011, 3, 5, 1);
        settle("R2 late change");
        // R9: back-to-back sets at the minimum tag period
        run_set({16'h0004, 16'h0003, 16'h0002, 16'h0001}, 4'b1111, 2, 2, 0);
        run_set({16'hA000, 16'h0000, 16'hB000, 16'h9000}, 4'b1011, 2, 2, 0);
        run_set({16'h0010, 16'h0020, 16'h0030, 16'h0040}, 4'b1111, 2, 2, 0);
        run_set({16'h5555, 16'h5555, 16'h1111, 16'hFFFF}, 4'b1110, 2, 2, 0);
        settle("R9 back to back");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule